// File: doc/BRIEF.md
# Conversion Cycle Timing Sequencer

This block reproduces the master-clock timing of a two-input converter that runs without pause. It runs on one system clock and moves forward only on cycles where a master-clock tick enable is high. All inputs are sampled on tick cycles only. After reset it counts out a settle period. It then raises a single-cycle completion pulse for every finished conversion. Each pulse carries the input that was converted. A warning pulse comes one tick before each completion.

Selecting the other input in the middle of a conversion throws that conversion away and starts again. The first result after a restart takes longer than later ones. A sleep request takes effect at the next completion, and conversions stop. A wake request brings conversions back after a start-up wait. The length of that wait depends on whether a strap selects a crystal clock or an external clock. Filter arithmetic and analog behaviour are not modelled.

Top module: `conv_cycle_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `done_o`, `warn_o`, `chan_o`, `ready_o` and `asleep_o` are all 0.
- R2: `ready_o` rises in the cycle after the POR_T-th tick that follows reset, and is high exactly while conversions run.
- R3: The first result after the settle period ends, after a restart or after a wake completes on the FIRST_T-th tick after that start tick. The start tick is the tick that ends the settle or wake wait, or the tick that restarts the conversion.
- R4: While running and undisturbed, consecutive results complete every PER_T ticks. `done_o` is high for the single cycle after the completing tick.
- R5: On a tick where `chan_sel_i` differs from the input being converted, the running conversion is aborted and no result is produced. This holds even on the tick that would have completed it. The next result completes FIRST_T ticks later.
- R6: `chan_o` gives the input converted for the latest result: 0 for the first input, 1 for the second. It changes only together with `done_o`.
- R7: `warn_o` pulses one tick before each completion, in the cycle after the second-to-last tick. It never coincides with `done_o`.
- R8: A `sleep_req_i` on a tick while running lets the next completion on a later tick still be delivered. `asleep_o` goes high in that same cycle. No completion then occurs until wake.
- R9: A `wake_req_i` on a tick while asleep starts a wait. The wait is EXT_T ticks if `ext_clk_i` is 1 on that tick, or XTAL_T ticks if it is 0. `ready_o` rises after the wait ends, and `asleep_o` stays high during the wait.
- R10: A channel change during the settle period or the wake wait does not lengthen it. The first result is tagged with the channel sampled on the tick that ends the wait.
- R11: On cycles with `tick_i` low, no timing advances and all other inputs are ignored.
- R12: `wake_req_i` has no effect while running. `sleep_req_i` has no effect when not running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Master-clock tick enable |
| chan_sel_i | input | 1 | Input select: 0 first input, 1 second input |
| sleep_req_i | input | 1 | Request to sleep after the next result |
| wake_req_i | input | 1 | Request to leave sleep |
| ext_clk_i | input | 1 | Strap: 1 external clock (short wake wait), 0 crystal |
| done_o | output | 1 | Single-cycle result-complete pulse |
| warn_o | output | 1 | Single-cycle pulse one tick before completion |
| chan_o | output | 1 | Input tag of the latest result |
| ready_o | output | 1 | Conversions running |
| asleep_o | output | 1 | Sleeping or waiting for the clock to restart |

## Verification
One corner case is a channel change on the very tick that would complete a conversion. A design that lets completion win there emits a stale result tagged with the old input. Other cases are a channel change during the settle period or the wake wait, and a wake on each strap setting. A design that restarts its wait on a channel change, or latches the strap at the wrong time, produces a late ready or the wrong delay. The sleep test counts completions between the request and `asleep_o`. Sleeping at once gives zero, and sleeping one conversion too late gives two. Long stretches with the tick low, with requests and channel flips applied during them, catch logic that reacts to inputs off tick cycles.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

    typedef enum logic [1:0] {
        PH_POR   = 2'd0,
        PH_RUN   = 2'd1,
        PH_SLEEP = 2'd2,
        PH_WAKE  = 2'd3
    } phase_e;

    typedef struct packed {
        logic done;
        logic warn;
        logic chan;
    } evt_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned top);
        return $clog2(top + 1);
    endfunction

endpackage

// File: rtl/cvs_span_counter.sv
module cvs_span_counter #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          restart_i,
    input  logic          en_i,
    input  logic [CW-1:0] limit_i,
    output logic          at_end_o,
    output logic          near_end_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_v;
    logic [CW-1:0] prev_v;

    assign last_v     = limit_i - CW'(1);
    assign prev_v     = limit_i - CW'(2);
    assign at_end_o   = en_i && tick_i && (cnt_q == last_v);
    assign near_end_o = en_i && tick_i && (cnt_q == prev_v);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart_i || at_end_o) begin
            cnt_q <= '0;
        end else if (en_i && tick_i) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < limit_i);

endmodule

// File: rtl/cvs_phase_ctrl.sv
module cvs_phase_ctrl
    import cvs_pkg::*;
#(
    parameter int unsigned POR_T   = 490,
    parameter int unsigned FIRST_T = 7358,
    parameter int unsigned PER_T   = 4884,
    parameter int unsigned XTAL_T  = 16384,
    parameter int unsigned EXT_T   = 98,
    parameter int unsigned CW      = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          chan_sel_i,
    input  logic          sleep_req_i,
    input  logic          wake_req_i,
    input  logic          ext_clk_i,
    input  logic          at_end_i,
    input  logic          near_end_i,
    output phase_e        phase_o,
    output logic [CW-1:0] limit_o,
    output logic          en_o,
    output logic          restart_o,
    output evt_t          evt_o
);
    phase_e phase_q, phase_d;
    logic   first_q, first_d;
    logic   ch_q, ch_d;
    logic   pend_q, pend_d;
    logic   ext_q, ext_d;
    logic   running;
    logic   abort;
    logic   done_ev;

    assign running   = (phase_q == PH_RUN);
    assign abort     = running && tick_i && (chan_sel_i != ch_q);
    assign done_ev   = running && at_end_i && !abort;
    assign restart_o = abort || ((phase_q == PH_SLEEP) && tick_i && wake_req_i);
    assign en_o      = (phase_q != PH_SLEEP);
    assign phase_o   = phase_q;

    always_comb begin
        evt_o.done = done_ev;
        evt_o.warn = running && near_end_i && !abort;
        evt_o.chan = ch_q;
    end

    always_comb begin
        case (phase_q)
            PH_POR:  limit_o = CW'(POR_T);
            PH_RUN:  limit_o = first_q ? CW'(FIRST_T) : CW'(PER_T);
            PH_WAKE: limit_o = ext_q ? CW'(EXT_T) : CW'(XTAL_T);
            default: limit_o = CW'(PER_T);
        endcase
    end

    always_comb begin
        phase_d = phase_q;
        first_d = first_q;
        ch_d    = ch_q;
        pend_d  = 1'b0;
        ext_d   = ext_q;
        case (phase_q)
            PH_POR: begin
                if (tick_i) ch_d = chan_sel_i;
                if (at_end_i) begin
                    phase_d = PH_RUN;
                    first_d = 1'b1;
                end
            end
            PH_RUN: begin
                pend_d = pend_q;
                if (abort) begin
                    ch_d    = chan_sel_i;
                    first_d = 1'b1;
                end else if (at_end_i) begin
                    first_d = 1'b0;
                    if (pend_q) phase_d = PH_SLEEP;
                end
                if (done_ev && pend_q) pend_d = 1'b0;
                else if (tick_i && sleep_req_i) pend_d = 1'b1;
            end
            PH_SLEEP: begin
                if (tick_i) begin
                    ch_d = chan_sel_i;
                    if (wake_req_i) begin
                        phase_d = PH_WAKE;
                        ext_d   = ext_clk_i;
                    end
                end
            end
            default: begin
                if (tick_i) ch_d = chan_sel_i;
                if (at_end_i) begin
                    phase_d = PH_RUN;
                    first_d = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_POR;
            first_q <= 1'b1;
            ch_q    <= 1'b0;
            pend_q  <= 1'b0;
            ext_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            first_q <= first_d;
            ch_q    <= ch_d;
            pend_q  <= pend_d;
            ext_q   <= ext_d;
        end
    end

    // R12
    pend_only_running_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> (phase_q == PH_RUN));

endmodule

// File: rtl/cvs_event_reg.sv
module cvs_event_reg
    import cvs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t evt_i,
    output logic done_o,
    output logic warn_o,
    output logic chan_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done_o <= 1'b0;
            warn_o <= 1'b0;
            chan_o <= 1'b0;
        end else begin
            done_o <= evt_i.done;
            warn_o <= evt_i.warn;
            if (evt_i.done) chan_o <= evt_i.chan;
        end
    end

    // R6
    chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(chan_o));

endmodule

// File: rtl/conv_cycle_seq.sv
module conv_cycle_seq
    import cvs_pkg::*;
#(
    parameter int unsigned POR_T   = 490,
    parameter int unsigned FIRST_T = 7358,
    parameter int unsigned PER_T   = 4884,
    parameter int unsigned XTAL_T  = 16384,
    parameter int unsigned EXT_T   = 98
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic chan_sel_i,
    input  logic sleep_req_i,
    input  logic wake_req_i,
    input  logic ext_clk_i,
    output logic done_o,
    output logic warn_o,
    output logic chan_o,
    output logic ready_o,
    output logic asleep_o
);
    localparam int unsigned TOP_T = max2(max2(max2(POR_T, FIRST_T), max2(PER_T, XTAL_T)), EXT_T);
    localparam int unsigned CW    = cnt_width(TOP_T);

    phase_e        phase;
    logic [CW-1:0] limit;
    logic          en;
    logic          restart;
    logic          at_end;
    logic          near_end;
    evt_t          evt;

    cvs_span_counter #(.CW(CW)) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .restart_i  (restart),
        .en_i       (en),
        .limit_i    (limit),
        .at_end_o   (at_end),
        .near_end_o (near_end)
    );

    cvs_phase_ctrl #(
        .POR_T(POR_T), .FIRST_T(FIRST_T), .PER_T(PER_T),
        .XTAL_T(XTAL_T), .EXT_T(EXT_T), .CW(CW)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .chan_sel_i  (chan_sel_i),
        .sleep_req_i (sleep_req_i),
        .wake_req_i  (wake_req_i),
        .ext_clk_i   (ext_clk_i),
        .at_end_i    (at_end),
        .near_end_i  (near_end),
        .phase_o     (phase),
        .limit_o     (limit),
        .en_o        (en),
        .restart_o   (restart),
        .evt_o       (evt)
    );

    cvs_event_reg evt_i (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .done_o (done_o),
        .warn_o (warn_o),
        .chan_o (chan_o)
    );

    assign ready_o  = (phase == PH_RUN);
    assign asleep_o = (phase == PH_SLEEP) || (phase == PH_WAKE);

    // R7
    done_warn_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_o && warn_o));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (asleep_o && $past(asleep_o)) |-> !done_o);

    // R8
    sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep_o) |-> done_o);

    // R2
    mode_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ready_o, asleep_o}));

endmodule

// File: tb/conv_cycle_seq_tb_top.sv
module conv_cycle_seq_tb_top;

    localparam int POR_T   = 12;
    localparam int FIRST_T = 30;
    localparam int PER_T   = 20;
    localparam int XTAL_T  = 40;
    localparam int EXT_T   = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_i = 1'b0, chan_sel_i = 1'b0, sleep_req_i = 1'b0, wake_req_i = 1'b0, ext_clk_i = 1'b0;
    logic done_o, warn_o, chan_o, ready_o, asleep_o;

    always #2 clk = ~clk;

    conv_cycle_seq #(
        .POR_T(POR_T), .FIRST_T(FIRST_T), .PER_T(PER_T), .XTAL_T(XTAL_T), .EXT_T(EXT_T)
    ) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .chan_sel_i(chan_sel_i),
        .sleep_req_i(sleep_req_i), .wake_req_i(wake_req_i), .ext_clk_i(ext_clk_i),
        .done_o(done_o), .warn_o(warn_o), .chan_o(chan_o), .ready_o(ready_o), .asleep_o(asleep_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int tick_no = 0;
    int ticks_at_check = 0;

    logic d_tick = 1'b1, d_chs = 1'b0, d_slp = 1'b0, d_wk = 1'b0, d_ext = 1'b0;

    int   m_st = 0, m_el = 0;
    logic m_first = 1'b1, m_ch = 1'b0, m_pend = 1'b0, m_ext = 1'b0;
    logic exp_done = 1'b0, exp_warn = 1'b0, exp_ch = 1'b0, exp_ready = 1'b0, exp_asleep = 1'b0;

    function automatic int run_lim(input logic first);
        return first ? FIRST_T : PER_T;
    endfunction

    function automatic int wake_lim(input logic ext);
        return ext ? EXT_T : XTAL_T;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic observe();
        @(negedge clk);
        cyc++;
        ticks_at_check = tick_no;
        chk(done_o === exp_done,     "R4 done_o",   int'(done_o),   int'(exp_done));
        chk(warn_o === exp_warn,     "R7 warn_o",   int'(warn_o),   int'(exp_warn));
        chk(chan_o === exp_ch,       "R6 chan_o",   int'(chan_o),   int'(exp_ch));
        chk(ready_o === exp_ready,   "R2 ready_o",  int'(ready_o),  int'(exp_ready));
        chk(asleep_o === exp_asleep, "R8 asleep_o", int'(asleep_o), int'(exp_asleep));
        if (cyc > 100000) begin
            chk(1'b0, "watchdog", cyc, 100000);
            finish_up();
        end
    endtask

    task automatic model_apply();
        int  lim;
        bit  slept;
        slept = 0;
        exp_done = 1'b0;
        exp_warn = 1'b0;
        if (d_tick) begin
            tick_no++;
            case (m_st)
                0: begin
                    m_ch = d_chs;
                    m_el++;
                    if (m_el == POR_T) begin m_st = 1; m_el = 0; m_first = 1'b1; end
                end
                1: begin
                    if (d_chs != m_ch) begin
                        m_ch = d_chs; m_el = 0; m_first = 1'b1;
                        if (d_slp) m_pend = 1'b1;
                    end else begin
                        m_el++;
                        lim = run_lim(m_first);
                        if (m_el == lim - 1) exp_warn = 1'b1;
                        if (m_el == lim) begin
                            exp_done = 1'b1; exp_ch = m_ch; m_el = 0; m_first = 1'b0;
                            if (m_pend) begin m_st = 2; m_pend = 1'b0; slept = 1; end
                        end
                        if (d_slp && !slept) m_pend = 1'b1;
                    end
                end
                2: begin
                    m_ch = d_chs;
                    if (d_wk) begin m_st = 3; m_el = 0; m_ext = d_ext; end
                end
                default: begin
                    m_ch = d_chs;
                    m_el++;
                    if (m_el == wake_lim(m_ext)) begin m_st = 1; m_el = 0; m_first = 1'b1; end
                end
            endcase
        end
        exp_ready  = (m_st == 1);
        exp_asleep = (m_st >= 2);
    endtask

    task automatic apply();
        tick_i      = d_tick;
        chan_sel_i  = d_chs;
        sleep_req_i = d_slp;
        wake_req_i  = d_wk;
        ext_clk_i   = d_ext;
        model_apply();
        d_slp = 1'b0;
        d_wk  = 1'b0;
    endtask

    task automatic wait_done(input int maxc);
        for (int i = 0; i < maxc; i++) begin
            observe();
            if (done_o) return;
            apply();
        end
        chk(1'b0, "wait for done_o", 0, 1);
    endtask

    task automatic wait_ready(input int maxc);
        for (int i = 0; i < maxc; i++) begin
            observe();
            if (ready_o) return;
            apply();
        end
        chk(1'b0, "wait for ready_o", 0, 1);
    endtask

    initial begin
        int mark;
        int ndone;
        void'($urandom(32'd20251));

        repeat (3) @(negedge clk);
        // R1: outputs held low in reset
        chk({done_o, warn_o, chan_o, ready_o, asleep_o} === 5'b0, "R1 reset outputs",
            int'({done_o, warn_o, chan_o, ready_o, asleep_o}), 0);
        rst = 1'b0;

        // R2 + R10: settle count, channel change inside it does not extend it
        for (int i = 0; i < 200; i++) begin
            observe();
            if (i == 0) chk(!done_o && !ready_o && !asleep_o, "R1 first cycle after reset", int'(ready_o), 0);
            if (i == 5) d_chs = 1'b1;
            if (ready_o) break;
            apply();
        end
        chk(ticks_at_check == POR_T, "R2 settle length", ticks_at_check, POR_T);
        apply();
        wait_done(200);
        chk(ticks_at_check == POR_T + FIRST_T, "R3 R10 first result after settle", ticks_at_check, POR_T + FIRST_T);
        chk(chan_o == 1'b1, "R10 tag after settle change", int'(chan_o), 1);

        // R4: steady period
        mark = ticks_at_check;
        apply();
        wait_done(200);
        chk(ticks_at_check - mark == PER_T, "R4 period", ticks_at_check - mark, PER_T);

        // R5 + R6: mid-conversion change
        apply();
        repeat (7) begin observe(); apply(); end
        observe();
        d_chs = 1'b0;
        apply();
        mark = tick_no;
        wait_done(200);
        chk(ticks_at_check - mark == FIRST_T, "R5 restart latency", ticks_at_check - mark, FIRST_T);
        chk(chan_o == 1'b0, "R6 tag input one", int'(chan_o), 0);

        // R5: change on the completing tick wins over completion
        apply();
        for (int i = 0; i < 200; i++) begin
            observe();
            if (warn_o) break;
            apply();
        end
        d_chs = 1'b1;
        apply();
        mark = tick_no;
        observe();
        chk(done_o == 1'b0, "R5 abort on completing tick", int'(done_o), 0);
        apply();
        wait_done(200);
        chk(ticks_at_check - mark == FIRST_T, "R5 restart after tie", ticks_at_check - mark, FIRST_T);
        chk(chan_o == 1'b1, "R6 tag input two", int'(chan_o), 1);

        // R12: wake while running is ignored
        mark = ticks_at_check;
        d_wk = 1'b1;
        apply();
        wait_done(200);
        chk(ticks_at_check - mark == PER_T, "R12 wake ignored when running", ticks_at_check - mark, PER_T);
        chk(asleep_o == 1'b0, "R12 still awake", int'(asleep_o), 0);

        // R8: sleep one conversion later
        d_slp = 1'b1;
        apply();
        ndone = 0;
        for (int i = 0; i < 200; i++) begin
            observe();
            if (done_o) ndone++;
            if (asleep_o) break;
            apply();
        end
        chk(ndone == 1, "R8 results before sleep", ndone, 1);
        chk(done_o == 1'b1, "R8 sleep entered with last result", int'(done_o), 1);
        for (int i = 0; i < 60; i++) begin
            apply();
            observe();
            chk(!done_o && asleep_o, "R8 quiet while asleep", int'(done_o), 0);
        end

        // R9 + R10: external-clock wake, channel change inside wait
        d_wk = 1'b1; d_ext = 1'b1;
        apply();
        mark = tick_no;
        for (int i = 0; i < 200; i++) begin
            observe();
            if (i == 3) d_chs = 1'b0;
            if (ready_o) break;
            apply();
        end
        chk(ticks_at_check - mark == EXT_T, "R9 external wake delay", ticks_at_check - mark, EXT_T);
        apply();
        wait_done(200);
        chk(ticks_at_check - mark == EXT_T + FIRST_T, "R10 first result after wake", ticks_at_check - mark, EXT_T + FIRST_T);
        chk(chan_o == 1'b0, "R10 tag after wake change", int'(chan_o), 0);

        // R9: crystal wake
        d_slp = 1'b1;
        apply();
        for (int i = 0; i < 200; i++) begin
            observe();
            if (asleep_o) break;
            apply();
        end
        d_wk = 1'b1; d_ext = 1'b0;
        apply();
        mark = tick_no;
        wait_ready(200);
        chk(ticks_at_check - mark == XTAL_T, "R9 crystal wake delay", ticks_at_check - mark, XTAL_T);
        apply();
        wait_done(200);

        // R11: inputs ignored with tick low
        mark = ticks_at_check;
        d_tick = 1'b0;
        for (int i = 0; i < 80; i++) begin
            if (i == 10) d_chs = ~d_chs;
            if (i == 20) d_slp = 1'b1;
            if (i == 30) d_wk = 1'b1;
            apply();
            observe();
            chk(!done_o && ready_o, "R11 frozen without tick", int'(done_o), 0);
        end
        d_chs = chan_o;
        d_tick = 1'b1;
        apply();
        wait_done(200);
        chk(ticks_at_check - mark == PER_T, "R11 period counts ticks only", ticks_at_check - mark, PER_T);
        chk(asleep_o == 1'b0, "R12 sleep ignored off tick", int'(asleep_o), 0);

        // random traffic checked against the bench model
        apply();
        for (int i = 0; i < 5000; i++) begin
            observe();
            d_tick = ($urandom % 4) != 0;
            if ($urandom % 150 == 0) d_chs = ~d_chs;
            if ($urandom % 250 == 0) d_slp = 1'b1;
            if ($urandom % 50 == 0) d_wk = 1'b1;
            d_ext = $urandom % 2;
            apply();
        end
        observe();
        finish_up();
    end

endmodule